// File: doc/BRIEF.md
# Network Controller Interrupt Status Aggregator

This block collects completion events from the transmit, receive and management paths of a network controller. It presents them to a host as a pair of maskable status registers on a plain 32-bit register bus. A 32-bit primary status register latches the transmit and receive events. A 16-bit management status register sits one level down, and its unmasked content is folded into a single summary position of the primary level. One level-sensitive interrupt line tells the host that some unmasked event is waiting.

Both status registers clear when the host reads them. The primary status keeps only its summary bit across a read. That bit belongs to the lower level and is cleared there. Two extra offsets mirror the primary status and primary mask for host software that uses the wrong addresses. The interrupt line comes from a two-state machine. `IRQ_QUIET` moves to `IRQ_RAISED` on the edge after any unmasked cause appears. `IRQ_RAISED` returns to `IRQ_QUIET` on the edge after the last cause has gone. The line is high exactly in `IRQ_RAISED`.

Top module: `nic_irq_aggregator`

## Requirements
- R1: After reset the primary status and management status read 0, the primary mask reads 0xFF7FFFFF, the management mask reads 0xFFFF and the interrupt is low. The offsets are: primary status 0x100, primary mask 0x104, management mask 0x114, management status 0x118.
- R2: A one-cycle pulse on `evt_rx`, `evt_tx_desc` or `evt_tx_all` sets primary status bit 16, 24 or 25 respectively.
- R3: A mask bit of 1 disables its source. Primary status bit 23 never raises the interrupt by itself, whatever its mask bit holds.
- R4: When any management status bit is set with its management mask bit at 0, the interrupt is raised even if primary mask bit 23 is 1.
- R5: A read of the primary status returns its current value. Afterwards every bit except bit 23 is 0.
- R6: A read of the management status returns its current value. Afterwards the register is 0. A pulse on `sub_evt` ORs into it.
- R7: Offset 0x108 reads and writes the primary status, including the clear on read. Offset 0x10C reads and writes the primary mask.
- R8: An event arriving in the same cycle as a clearing read is kept in the status register.
- R9: A write to an unmapped offset changes no register. A read of an unmapped offset returns 0.
- R10: The interrupt output is registered. It changes on the clock edge after the edge that changed a status or mask register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the 32-bit register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during the access cycle |
| evt_rx | input | 1 | Receive frame delivered to host |
| evt_tx_desc | input | 1 | Transmit descriptor finished |
| evt_tx_all | input | 1 | Transmit queue drained |
| sub_evt | input | SUB_W | Management event bits, ORed into management status |
| irq_o | output | 1 | Level interrupt to host |

## Verification
The masking function is swept one bit at a time over every primary status position, with each bit both masked and unmasked. This separates a correct mask inversion from a wrong bit index and shows that position 23 alone never fires. The same sweep over all sixteen management positions, with primary mask bit 23 held at 1, shows that the fold overrides the primary mask. Read sequences on all-ones status, on alias offsets and with an event in the same cycle as the read tell the kept summary bit, the alias decode and the event priority apart from a blanket clear.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;

    localparam int MAIN_W  = 32;
    localparam int RX_BIT  = 16;
    localparam int SUB_BIT = 23;
    localparam int TXD_BIT = 24;
    localparam int TXA_BIT = 25;

    localparam logic [15:0] OFF_MSTAT     = 16'h0100;
    localparam logic [15:0] OFF_MMASK     = 16'h0104;
    localparam logic [15:0] OFF_MSTAT_ALT = 16'h0108;
    localparam logic [15:0] OFF_MMASK_ALT = 16'h010C;
    localparam logic [15:0] OFF_SMASK     = 16'h0114;
    localparam logic [15:0] OFF_SSTAT     = 16'h0118;

    localparam logic [MAIN_W-1:0] MMASK_RST = 32'hFF7F_FFFF;
    localparam logic [MAIN_W-1:0] KEEP_MASK = 32'h0080_0000;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MSTAT,
        SEL_MMASK,
        SEL_SSTAT,
        SEL_SMASK
    } reg_sel_e;

    typedef enum logic {
        IRQ_QUIET,
        IRQ_RAISED
    } irq_state_e;

endpackage

// File: rtl/nic_irq_decode.sv
module nic_irq_decode
    import nic_irq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_sel_e          sel,
    output logic              rd_mstat,
    output logic              rd_sstat,
    output logic              wr_mstat,
    output logic              wr_mmask,
    output logic              wr_sstat,
    output logic              wr_smask
);

    always_comb begin
        sel = SEL_NONE;
        if (bus_sel) begin
            if (bus_addr == OFF_MSTAT[ADDR_W-1:0] || bus_addr == OFF_MSTAT_ALT[ADDR_W-1:0])
                sel = SEL_MSTAT;
            else if (bus_addr == OFF_MMASK[ADDR_W-1:0] || bus_addr == OFF_MMASK_ALT[ADDR_W-1:0])
                sel = SEL_MMASK;
            else if (bus_addr == OFF_SSTAT[ADDR_W-1:0])
                sel = SEL_SSTAT;
            else if (bus_addr == OFF_SMASK[ADDR_W-1:0])
                sel = SEL_SMASK;
        end
    end

    always_comb begin
        rd_mstat = (sel == SEL_MSTAT) && !bus_wr;
        rd_sstat = (sel == SEL_SSTAT) && !bus_wr;
        wr_mstat = (sel == SEL_MSTAT) && bus_wr;
        wr_mmask = (sel == SEL_MMASK) && bus_wr;
        wr_sstat = (sel == SEL_SSTAT) && bus_wr;
        wr_smask = (sel == SEL_SMASK) && bus_wr;
    end

endmodule

// File: rtl/nic_irq_main_regs.sv
module nic_irq_main_regs
    import nic_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stat,
    input  logic              wr_mask,
    input  logic              rd_stat,
    input  logic [MAIN_W-1:0] wdata,
    input  logic [MAIN_W-1:0] evt_set,
    output logic [MAIN_W-1:0] stat_q,
    output logic [MAIN_W-1:0] mask_q,
    output logic              main_any
);

    logic [MAIN_W-1:0] stat_base;
    logic [MAIN_W-1:0] stat_d;

    always_comb begin
        if (wr_stat)
            stat_base = wdata;
        else if (rd_stat)
            stat_base = stat_q & KEEP_MASK;
        else
            stat_base = stat_q;
        stat_d = stat_base | evt_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            mask_q <= MMASK_RST;
        end else begin
            stat_q <= stat_d;
            if (wr_mask)
                mask_q <= wdata;
        end
    end

    assign main_any = |(stat_q & ~mask_q & ~KEEP_MASK);

endmodule

// File: rtl/nic_irq_sub_regs.sv
module nic_irq_sub_regs #(
    parameter int SUB_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stat,
    input  logic             wr_mask,
    input  logic             rd_stat,
    input  logic [SUB_W-1:0] wdata,
    input  logic [SUB_W-1:0] evt_set,
    output logic [SUB_W-1:0] stat_q,
    output logic [SUB_W-1:0] mask_q,
    output logic             sub_any
);

    logic [SUB_W-1:0] stat_d;

    always_comb begin
        if (wr_stat)
            stat_d = wdata | evt_set;
        else if (rd_stat)
            stat_d = evt_set;
        else
            stat_d = stat_q | evt_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            mask_q <= '1;
        end else begin
            stat_q <= stat_d;
            if (wr_mask)
                mask_q <= wdata;
        end
    end

    assign sub_any = |(stat_q & ~mask_q);

endmodule

// File: rtl/nic_irq_fsm.sv
module nic_irq_fsm
    import nic_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic irq
);

    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= IRQ_QUIET;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (pending)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!pending) state_d = IRQ_QUIET;
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_RAISED);
    end

endmodule

// File: rtl/nic_irq_aggregator.sv
module nic_irq_aggregator
    import nic_irq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SUB_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              evt_rx,
    input  logic              evt_tx_desc,
    input  logic              evt_tx_all,
    input  logic [SUB_W-1:0]  sub_evt,
    output logic              irq_o
);

    localparam int PAD_W = MAIN_W - SUB_W;

    reg_sel_e          sel;
    logic              rd_mstat, rd_sstat;
    logic              wr_mstat, wr_mmask, wr_sstat, wr_smask;
    logic [MAIN_W-1:0] evt_vec;
    logic [MAIN_W-1:0] mstat_q, mmask_q;
    logic [SUB_W-1:0]  sstat_q, smask_q;
    logic              main_any, sub_any;

    nic_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .sel      (sel),
        .rd_mstat (rd_mstat),
        .rd_sstat (rd_sstat),
        .wr_mstat (wr_mstat),
        .wr_mmask (wr_mmask),
        .wr_sstat (wr_sstat),
        .wr_smask (wr_smask)
    );

    always_comb begin
        evt_vec          = '0;
        evt_vec[RX_BIT]  = evt_rx;
        evt_vec[TXD_BIT] = evt_tx_desc;
        evt_vec[TXA_BIT] = evt_tx_all;
    end

    nic_irq_main_regs u_main (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stat  (wr_mstat),
        .wr_mask  (wr_mmask),
        .rd_stat  (rd_mstat),
        .wdata    (bus_wdata),
        .evt_set  (evt_vec),
        .stat_q   (mstat_q),
        .mask_q   (mmask_q),
        .main_any (main_any)
    );

    nic_irq_sub_regs #(.SUB_W(SUB_W)) u_sub (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stat (wr_sstat),
        .wr_mask (wr_smask),
        .rd_stat (rd_sstat),
        .wdata   (bus_wdata[SUB_W-1:0]),
        .evt_set (sub_evt),
        .stat_q  (sstat_q),
        .mask_q  (smask_q),
        .sub_any (sub_any)
    );

    nic_irq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (main_any | sub_any),
        .irq     (irq_o)
    );

    always_comb begin
        unique case (sel)
            SEL_MSTAT: bus_rdata = mstat_q;
            SEL_MMASK: bus_rdata = mmask_q;
            SEL_SSTAT: bus_rdata = {{PAD_W{1'b0}}, sstat_q};
            SEL_SMASK: bus_rdata = {{PAD_W{1'b0}}, smask_q};
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/nic_irq_aggregator_chk.sv
module nic_irq_aggregator_chk
    import nic_irq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SUB_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              evt_rx,
    input logic              evt_tx_desc,
    input logic              evt_tx_all,
    input logic [SUB_W-1:0]  sub_evt,
    input logic              irq_o,
    input logic [MAIN_W-1:0] mstat,
    input logic [MAIN_W-1:0] mmask,
    input logic [SUB_W-1:0]  sstat,
    input logic [SUB_W-1:0]  smask
);

    logic rd_m, rd_s, evt_any, cause_main, cause_sub;

    always_comb begin
        rd_m = bus_sel && !bus_wr &&
               (bus_addr == OFF_MSTAT[ADDR_W-1:0] || bus_addr == OFF_MSTAT_ALT[ADDR_W-1:0]);
        rd_s = bus_sel && !bus_wr && (bus_addr == OFF_SSTAT[ADDR_W-1:0]);
        evt_any    = evt_rx | evt_tx_desc | evt_tx_all;
        cause_main = |(mstat & ~mmask & ~KEEP_MASK);
        cause_sub  = |(sstat & ~smask);
    end

    p_reset_masks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (mmask == MMASK_RST && smask == '1));

    p_rx_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(evt_rx) |-> mstat[RX_BIT]);

    p_irq_tracks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(cause_main || cause_sub));

    p_fold_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cause_sub) |-> irq_o);

    p_main_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_m && !evt_any) |-> (mstat == ($past(mstat) & KEEP_MASK)));

    p_sub_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_s && sub_evt == '0) |-> (sstat == '0));

    p_evt_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_m && evt_tx_desc) |-> mstat[TXD_BIT]);

endmodule

bind nic_irq_aggregator nic_irq_aggregator_chk #(.ADDR_W(ADDR_W), .SUB_W(SUB_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .evt_rx      (evt_rx),
    .evt_tx_desc (evt_tx_desc),
    .evt_tx_all  (evt_tx_all),
    .sub_evt     (sub_evt),
    .irq_o       (irq_o),
    .mstat       (mstat_q),
    .mmask       (mmask_q),
    .sstat       (sstat_q),
    .smask       (smask_q)
);

// File: tb/nic_irq_aggregator_test.sv
`timescale 1ns/1ps
module nic_irq_aggregator_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        evt_rx = 1'b0;
    logic        evt_tx_desc = 1'b0;
    logic        evt_tx_all = 1'b0;
    logic [15:0] sub_evt = '0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    nic_irq_aggregator uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_rx(evt_rx), .evt_tx_desc(evt_tx_desc), .evt_tx_all(evt_tx_all),
        .sub_evt(sub_evt), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic bus_op(input logic wr, input logic [11:0] a, input logic [31:0] d,
                          input logic rx, input logic txd, input logic [15:0] se,
                          output logic [31:0] rd);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        evt_rx = rx; evt_tx_desc = txd; sub_evt = se;
        #1 rd = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; evt_rx = 1'b0; evt_tx_desc = 1'b0; sub_evt = '0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] dummy;
        bus_op(1'b1, a, d, 1'b0, 1'b0, 16'h0, dummy);
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        bus_op(1'b0, a, 32'h0, 1'b0, 1'b0, 16'h0, v);
    endtask

    task automatic pulse(input logic rx, input logic txd, input logic txa);
        @(negedge clk);
        evt_rx = rx; evt_tx_desc = txd; evt_tx_all = txa;
        @(negedge clk);
        evt_rx = 1'b0; evt_tx_desc = 1'b0; evt_tx_all = 1'b0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {31'h0, irq_o}, 32'h0);
        rd(12'h100, v); check("R1 mstat", v, 32'h0);
        rd(12'h104, v); check("R1 mmask", v, 32'hFF7F_FFFF);
        rd(12'h114, v); check("R1 smask", v, 32'h0000_FFFF);
        rd(12'h118, v); check("R1 sstat", v, 32'h0);

        // R9 unmapped offsets
        wr(12'h200, 32'hFFFF_FFFF);
        rd(12'h200, v); check("R9 unmapped read", v, 32'h0);
        wr(12'h104 + 12'h1, 32'h0);
        rd(12'h104, v); check("R9 mask untouched", v, 32'hFF7F_FFFF);
        check("R9 irq quiet", {31'h0, irq_o}, 32'h0);

        // R10 latency
        wr(12'h104, 32'hFFFF_FFFE);
        wr(12'h100, 32'h0000_0001);
        check("R10 irq before next edge", {31'h0, irq_o}, 32'h0);
        @(negedge clk);
        check("R10 irq one edge later", {31'h0, irq_o}, 32'h1);
        wr(12'h100, 32'h0);

        // R3 sweep over every primary bit, masked and unmasked
        for (int i = 0; i < 32; i++) begin
            for (int m = 0; m < 2; m++) begin
                logic exp_irq;
                wr(12'h104, (m == 1) ? 32'hFFFF_FFFF : ~(32'h1 << i));
                wr(12'h100, 32'h1 << i);
                @(negedge clk);
                exp_irq = (i != 23) && (m == 0);
                check($sformatf("R3 bit %0d mask %0d", i, m), {31'h0, irq_o}, {31'h0, exp_irq});
                wr(12'h100, 32'h0);
            end
        end

        // R4 sweep over management bits with primary bit 23 masked
        wr(12'h104, 32'hFFFF_FFFF);
        for (int j = 0; j < 16; j++) begin
            for (int m = 0; m < 2; m++) begin
                logic [15:0] sm;
                sm = (m == 1) ? 16'hFFFF : ~(16'h1 << j);
                wr(12'h114, {16'h0, sm});
                wr(12'h118, {16'h0, 16'h1 << j});
                @(negedge clk);
                check($sformatf("R4 sub bit %0d mask %0d", j, m), {31'h0, irq_o}, {31'h0, (m == 0)});
                wr(12'h118, 32'h0);
            end
        end
        wr(12'h114, 32'h0000_FFFF);

        // R2 event inputs
        pulse(1'b1, 1'b0, 1'b0);
        rd(12'h100, v); check("R2 rx bit 16", v, 32'h0001_0000);
        rd(12'h100, v); check("R5 cleared after read", v, 32'h0);
        pulse(1'b0, 1'b1, 1'b0);
        pulse(1'b0, 1'b0, 1'b1);
        rd(12'h100, v); check("R2 tx bits 24 25", v, 32'h0300_0000);

        // R5 read keeps only bit 23
        wr(12'h100, 32'hFFFF_FFFF);
        rd(12'h100, v); check("R5 read value", v, 32'hFFFF_FFFF);
        rd(12'h100, v); check("R5 keeps bit 23", v, 32'h0080_0000);
        wr(12'h100, 32'h0);

        // R6 management status
        bus_op(1'b0, 12'h200, 32'h0, 1'b0, 1'b0, 16'h00F0, v);
        rd(12'h118, v); check("R6 sub event", v, 32'h0000_00F0);
        rd(12'h118, v); check("R6 sub cleared", v, 32'h0);

        // R7 aliases
        wr(12'h10C, 32'h1234_5678);
        rd(12'h104, v); check("R7 mask alias write", v, 32'h1234_5678);
        wr(12'h104, 32'hFFFF_FFFF);
        rd(12'h10C, v); check("R7 mask alias read", v, 32'hFFFF_FFFF);
        wr(12'h108, 32'h0000_0F0F);
        rd(12'h100, v); check("R7 status alias write", v, 32'h0000_0F0F);
        wr(12'h100, 32'h0000_00AA);
        rd(12'h108, v); check("R7 status alias read", v, 32'h0000_00AA);
        rd(12'h100, v); check("R7 alias read clears", v, 32'h0);

        // R8 event beats clearing read
        wr(12'h100, 32'h0100_0000);
        bus_op(1'b0, 12'h100, 32'h0, 1'b1, 1'b0, 16'h0, v);
        check("R8 read returns old", v, 32'h0100_0000);
        rd(12'h100, v); check("R8 rx kept", v, 32'h0001_0000);
        bus_op(1'b0, 12'h100, 32'h0, 1'b0, 1'b1, 16'h0, v);
        rd(12'h100, v); check("R8 tx desc kept", v, 32'h0100_0000);
        wr(12'h118, 32'h0000_0003);
        bus_op(1'b0, 12'h118, 32'h0, 1'b0, 1'b0, 16'h8000, v);
        check("R8 sub read old", v, 32'h0000_0003);
        rd(12'h118, v); check("R8 sub event kept", v, 32'h0000_8000);

        finish_run();
    end

endmodule